// File: doc/BRIEF.md
# 32-to-16-bit External Bus Sizer

This block connects a 32-bit internal request port to an external data bus whose width is chosen by a strap input. The strap is read while reset is held. With the strap inactive, the bus runs 32 bits wide and every byte lane maps straight through. With it active, the bus is 16 bits wide. All traffic then moves on data lines 15:0, and lines 31:16 are never driven.

In narrow mode, two of the four byte-enable outputs take new roles. One becomes a strobe for the high byte of the 16-bit bus, and the other carries address bit 1. When an upper halfword is accessed, its bytes travel on the low data lines in both directions.

Each access is one address state followed by one strobe state. In narrow mode, a full-word request is split into two such pairs, lower halfword first. Read data is merged lane by lane into a 32-bit read buffer. Write data is taken from a 32-bit write buffer that is captured when the request is accepted.

Top module: `bus_sizer`

## Requirements
- R1: The width strap is loaded into the mode flag only while rst_ni is low. `narrow_o` shows the flag, and later strap changes do not alter it until the next reset.
- R2: In narrow mode, `data_oe_o[1]` (the enable for data lines 31:16) stays 0 and `data_o[31:16]` stays 0 in every cycle.
- R3: In narrow mode, during an access `be_o[2]` is the strobe for data lines 15:8, and `be_o[3]` carries address bit 1 of the halfword being transferred.
- R4: In narrow mode, `be_o[0]` and `be_o[1]` are both the enable for data lines 7:0. Each access size sets them as follows:
  - Upper-byte access (address bit 0 = 1): the high strobe is 1 and the low enables are 0.
  - Lower-byte access: the low enables are 1 and the high strobe is 0.
  - Halfword access: all three are 1.
- R5: A byte or halfword access (`req_size_i` 0 = byte, 1 = halfword) runs one cycle with `bus_ta_o` high, then one cycle with `bus_ts_o` high. `done_o` pulses in the cycle after that.
- R6: On a narrow-mode upper-halfword read, the value on `data_i[15:0]` at the end of the strobe state lands in `rbuf_o[31:16]`.
- R7: On a narrow-mode upper-halfword write, `data_o[15:0]` carries bits 31:16 of the captured write buffer during the strobe state.
- R8: In narrow mode, a word access (`req_size_i` 2 or 3) runs two address/strobe pairs. `be_o[3]` is 0 in the first pair and 1 in the second. `done_o` pulses only after the second pair.
- R9: In wide mode:
  - `be_o[k]` is set exactly for the addressed byte lanes.
  - Data lanes map one to one between the buses and the buffers.
  - Both halves of `data_oe_o` are driven in the strobe state of a write.
- R10: `data_oe_o` is nonzero only in the strobe state of a write.
- R11: Read-buffer byte lanes outside the access are unchanged by a read, and no lane changes on a write.
- R12: A request presented while an access is in progress is ignored. Its fields do not affect the access that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width16_strap_i | input | 1 | Selects 16-bit bus when high, sampled during reset |
| req_valid_i | input | 1 | Request presented |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr_i | input | 2 | Low address bits of the access |
| wbuf_i | input | 32 | Write buffer contents |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rbuf_o | output | 32 | Read buffer |
| narrow_o | output | 1 | Captured 16-bit mode flag |
| bus_ta_o | output | 1 | Address state |
| bus_ts_o | output | 1 | Strobe/data state |
| be_o | output | 4 | Byte enables; in narrow mode {A1, byte-high, low, low} |
| data_i | input | 32 | External data in |
| data_o | output | 32 | External data out |
| data_oe_o | output | 2 | Output enables: bit 0 lines 15:0, bit 1 lines 31:16 |

## Verification
Directed accesses cover the lower and upper byte, both halfword positions and a full word, in each bus mode. These separate the lane-steering choices: a mix-up between upper and lower halfword, or between high and low byte, shows up as wrong enables, wrong data lines or a wrong read-buffer lane. Random accesses then mix sizes, addresses and directions. They also place random values on the unused upper data lines in narrow mode, which shows whether those lines leak into the read buffer. Some requests are held active during a transfer while their fields change, to show that a busy sizer ignores them. A second reset with the opposite strap, followed by strap toggling, separates a captured mode flag from a live one.

// File: rtl/bus_sizer_pkg.sv
package bus_sizer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2
  } bus_st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/bus_sizer_seq.sv
module bus_sizer_seq
  import bus_sizer_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int AW    = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              narrow_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] wbuf_i,
  output logic              ta_o,
  output logic              ts_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              write_o,
  output logic              half_sel_o,
  output logic [LANES-1:0]  mask_o,
  output logic [DATA_W-1:0] wbuf_o
);
  bus_st_e           st_q;
  logic              phase_q, write_q, done_q;
  logic [1:0]        size_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wbuf_q;
  logic [LANES-1:0]  mask;
  logic              split;

  always_comb begin
    case (size_q)
      SZ_BYTE: mask = LANES'(1) << addr_q;
      SZ_HALF: mask = LANES'(3) << {addr_q[AW-1:1], 1'b0};
      default: mask = '1;
    endcase
  end

  assign split = narrow_i && (mask == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
      write_q <= 1'b0;
      done_q  <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wbuf_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          write_q <= req_write_i;
          size_q  <= req_size_i;
          addr_q  <= req_addr_i;
          wbuf_q  <= wbuf_i;
          phase_q <= 1'b0;
          st_q    <= ST_ADDR;
        end
        ST_ADDR: st_q <= ST_STRB;
        ST_STRB: begin
          if (split && !phase_q) begin
            phase_q <= 1'b1;
            st_q    <= ST_ADDR;
          end else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ta_o       = (st_q == ST_ADDR);
  assign ts_o       = (st_q == ST_STRB);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign write_o    = write_q;
  assign half_sel_o = split ? phase_q : addr_q[AW-1];
  assign mask_o     = mask;
  assign wbuf_o     = wbuf_q;
endmodule

// File: rtl/bus_sizer_lanes.sv
module bus_sizer_lanes #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int HLANES = LANES / 2
) (
  input  logic              narrow_i,
  input  logic              ta_i,
  input  logic              ts_i,
  input  logic              write_i,
  input  logic              half_sel_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [DATA_W-1:0] wbuf_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] data_o,
  output logic [1:0]        data_oe_o
);
  logic              active, drive;
  logic [HLANES-1:0] cyc_en;
  logic [HALF_W-1:0] half_data;

  assign active    = ta_i | ts_i;
  assign drive     = ts_i & write_i;
  assign half_data = half_sel_i ? wbuf_i[DATA_W-1:HALF_W] : wbuf_i[HALF_W-1:0];

  for (genvar j = 0; j < HLANES; j++) begin : g_cyc
    assign cyc_en[j] = half_sel_i ? mask_i[HLANES + j] : mask_i[j];
  end

  always_comb begin
    if (narrow_i) begin
      // {A1, byte-high strobe, low-byte enable x2}
      be_o      = active ? {half_sel_i, cyc_en[1], cyc_en[0], cyc_en[0]} : '0;
      data_o    = {{HALF_W{1'b0}}, half_data};
      data_oe_o = {1'b0, drive};
    end else begin
      be_o      = active ? mask_i : '0;
      data_o    = wbuf_i;
      data_oe_o = {drive, drive};
    end
  end
endmodule

// File: rtl/bus_sizer_rdbuf.sv
module bus_sizer_rdbuf #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int HLANES = LANES / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              narrow_i,
  input  logic              ts_i,
  input  logic              write_i,
  input  logic              half_sel_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rbuf_o
);
  logic capture;
  assign capture = ts_i & ~write_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int BusLane = k % HLANES;
    localparam bit InHigh  = (k / HLANES) == 1;
    logic       en;
    logic [7:0] src, q;

    assign en  = capture && mask_i[k] && (!narrow_i || (half_sel_i == InHigh));
    assign src = narrow_i ? data_i[8*BusLane +: 8] : data_i[8*k +: 8];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (en)  q <= src;
    end
    assign rbuf_o[8*k +: 8] = q;
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int AW    = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              width16_strap_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] wbuf_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rbuf_o,
  output logic              narrow_o,
  output logic              bus_ta_o,
  output logic              bus_ts_o,
  output logic [LANES-1:0]  be_o,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [1:0]        data_oe_o
);
  logic              narrow_q, ta, ts, write_q, half_sel;
  logic [LANES-1:0]  mask;
  logic [DATA_W-1:0] wbuf_q;

  // strap follows input only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) narrow_q <= width16_strap_i;
    else         narrow_q <= narrow_q;
  end

  bus_sizer_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni,
    .narrow_i   (narrow_q),
    .req_valid_i, .req_write_i, .req_size_i, .req_addr_i, .wbuf_i,
    .ta_o       (ta),
    .ts_o       (ts),
    .busy_o,
    .done_o,
    .write_o    (write_q),
    .half_sel_o (half_sel),
    .mask_o     (mask),
    .wbuf_o     (wbuf_q)
  );

  bus_sizer_lanes #(.DATA_W(DATA_W)) u_lanes (
    .narrow_i   (narrow_q),
    .ta_i       (ta),
    .ts_i       (ts),
    .write_i    (write_q),
    .half_sel_i (half_sel),
    .mask_i     (mask),
    .wbuf_i     (wbuf_q),
    .be_o,
    .data_o,
    .data_oe_o
  );

  bus_sizer_rdbuf #(.DATA_W(DATA_W)) u_rdbuf (
    .clk_i, .rst_ni,
    .narrow_i   (narrow_q),
    .ts_i       (ts),
    .write_i    (write_q),
    .half_sel_i (half_sel),
    .mask_i     (mask),
    .data_i,
    .rbuf_o
  );

  assign narrow_o = narrow_q;
  assign bus_ta_o = ta;
  assign bus_ts_o = ts;
endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        narrow_o,
  input logic        bus_ta_o,
  input logic        bus_ts_o,
  input logic        done_o,
  input logic [3:0]  be_o,
  input logic [31:0] data_i,
  input logic [31:0] data_o,
  input logic [1:0]  data_oe_o,
  input logic [31:0] rbuf_o
);
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(narrow_o)); // R1
  AST_UPPER_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_o |-> (data_oe_o[1] == 1'b0 && data_o[31:16] == 16'h0)); // R2
  AST_LOW_ENABLES_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow_o && (bus_ta_o || bus_ts_o)) |-> (be_o[0] == be_o[1])); // R4
  AST_ADDR_THEN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ta_o |=> (bus_ts_o && !bus_ta_o)); // R5
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_ts_o)); // R5
  AST_UPPER_READ_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow_o && bus_ts_o && data_oe_o == 2'b00 && be_o[3] && be_o[2])
      |=> (rbuf_o[31:24] == $past(data_i[15:8]))); // R6
  AST_OE_ONLY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != 2'b00) |-> bus_ts_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_ta_o || bus_ts_o) |-> (be_o == 4'h0)); // R3
endmodule

bind bus_sizer bus_sizer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .narrow_o  (narrow_o),
  .bus_ta_o  (bus_ta_o),
  .bus_ts_o  (bus_ts_o),
  .done_o    (done_o),
  .be_o      (be_o),
  .data_i    (data_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .rbuf_o    (rbuf_o)
);

// File: tb/bus_sizer_bench.sv
module bus_sizer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        width16_strap_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_size_i = '0;
  logic [1:0]  req_addr_i = '0;
  logic [31:0] wbuf_i = '0;
  logic [31:0] data_i = '0;
  logic        busy_o, done_o, narrow_o, bus_ta_o, bus_ts_o;
  logic [31:0] rbuf_o, data_o;
  logic [3:0]  be_o;
  logic [1:0]  data_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic        narrow_m;
  logic [31:0] rbuf_m;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_sizer u_bus_sizer (.*);

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] ad);
    case (sz)
      2'd0:    return 4'b0001 << ad;
      2'd1:    return ad[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [3:0] exp_be(input logic [3:0] m, input logic h);
    logic lo, hi;
    if (!narrow_m) return m;
    lo = h ? m[2] : m[0];
    hi = h ? m[3] : m[1];
    return {h, hi, lo, lo};
  endfunction

  function automatic logic [31:0] exp_dout(input logic [31:0] w, input logic h);
    if (!narrow_m) return w;
    return {16'h0, h ? w[31:16] : w[15:0]};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [3:0] m,
                                        input logic h, input logic [31:0] d);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) begin
      if (m[k]) begin
        if (!narrow_m) r[8*k +: 8] = d[8*k +: 8];
        else if ((k / 2) == int'(h)) r[8*k +: 8] = d[8*(k % 2) +: 8];
      end
    end
    return r;
  endfunction

  task automatic do_reset(input logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0;
    width16_strap_i = strap;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    narrow_m = strap;
    rbuf_m = '0;
    @(negedge clk_i);
    chk(narrow_o == strap, "R1 reset mode", {31'b0, narrow_o}, {31'b0, strap});
    chk(!busy_o && !done_o && be_o == 4'h0, "R5 reset idle", {busy_o, done_o, be_o}, '0);
    chk(rbuf_o == 32'h0, "R11 reset rbuf", rbuf_o, 32'h0);
    chk(data_oe_o == 2'b00, "R10 reset oe", {30'b0, data_oe_o}, '0);
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [1:0] ad,
                        input logic [31:0] wd, input bit hold);
    logic [3:0] m;
    int nh;
    logic h;
    logic [31:0] din;
    m  = lane_mask(sz, ad);
    nh = (narrow_m && m == 4'hf) ? 2 : 1;
    chk(!busy_o && be_o == 4'h0 && data_oe_o == 2'b00, "R10 idle before request",
        {busy_o, be_o, data_oe_o}, '0);
    req_valid_i = 1'b1; req_write_i = wr; req_size_i = sz; req_addr_i = ad; wbuf_i = wd;
    @(negedge clk_i);
    if (hold) begin
      // R12: fields change while busy and must not matter
      req_write_i = ~wr; req_size_i = ~sz; req_addr_i = ~ad; wbuf_i = ~wd;
    end else begin
      req_valid_i = 1'b0;
    end
    for (int hi = 0; hi < nh; hi++) begin
      h = (nh == 2) ? hi[0] : ad[1];
      chk(bus_ta_o && !bus_ts_o, "R5 address state", {30'b0, bus_ta_o, bus_ts_o}, 32'h2);
      chk(be_o == exp_be(m, h), narrow_m ? "R3 R4 R8 be in address state" : "R9 be address",
          {28'b0, be_o}, {28'b0, exp_be(m, h)});
      chk(data_oe_o == 2'b00, "R10 oe in address state", {30'b0, data_oe_o}, '0);
      chk(!done_o, "R8 no early done", {31'b0, done_o}, '0);
      @(negedge clk_i);
      chk(bus_ts_o && !bus_ta_o, "R5 strobe state", {30'b0, bus_ta_o, bus_ts_o}, 32'h1);
      chk(be_o == exp_be(m, h), narrow_m ? "R3 R4 R8 be in strobe state" : "R9 be strobe",
          {28'b0, be_o}, {28'b0, exp_be(m, h)});
      if (wr) begin
        chk(data_oe_o == (narrow_m ? 2'b01 : 2'b11), "R9 R10 oe in write strobe",
            {30'b0, data_oe_o}, narrow_m ? 32'h1 : 32'h3);
        chk(data_o == exp_dout(wd, h), narrow_m ? "R7 narrow write data" : "R9 wide write data",
            data_o, exp_dout(wd, h));
      end else begin
        chk(data_oe_o == 2'b00, "R10 oe in read strobe", {30'b0, data_oe_o}, '0);
      end
      if (narrow_m)
        chk(data_oe_o[1] == 1'b0 && data_o[31:16] == 16'h0, "R2 upper undriven",
            {data_o[31:16], 14'b0, data_oe_o}, '0);
      din = $urandom;
      data_i = din;
      if (!wr) rbuf_m = merge(rbuf_m, m, h, din);
      if (hold && hi == nh - 1) req_valid_i = 1'b0;
      @(negedge clk_i);
    end
    chk(done_o && !busy_o, "R5 R8 done after last strobe", {30'b0, done_o, busy_o}, 32'h2);
    chk(rbuf_o == rbuf_m, narrow_m ? "R6 R11 read buffer" : "R9 R11 read buffer", rbuf_o, rbuf_m);
    data_i = $urandom;
    @(negedge clk_i);
    chk(!done_o, "R5 done single pulse", {31'b0, done_o}, '0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // wide mode
    do_reset(1'b0);
    access(1'b0, 2'd2, 2'd0, 32'h0, 1'b0);
    access(1'b1, 2'd2, 2'd0, 32'hA1B2C3D4, 1'b0);
    access(1'b0, 2'd0, 2'd3, 32'h0, 1'b0);
    access(1'b1, 2'd1, 2'd2, 32'h11223344, 1'b1);
    for (int i = 0; i < 300; i++)
      access($urandom_range(0, 1), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
             $urandom, bit'($urandom_range(0, 1)));

    // narrow mode, then strap toggles that must be ignored
    do_reset(1'b1);
    width16_strap_i = 1'b0;
    access(1'b0, 2'd1, 2'd2, 32'h0, 1'b0);          // R6 upper halfword read
    access(1'b1, 2'd1, 2'd2, 32'hCAFE0123, 1'b0);   // R7 upper halfword write
    access(1'b0, 2'd1, 2'd0, 32'h0, 1'b0);          // lower halfword read
    access(1'b0, 2'd0, 2'd3, 32'h0, 1'b0);          // R4 upper byte
    access(1'b0, 2'd0, 2'd0, 32'h0, 1'b0);          // R4 lower byte
    access(1'b0, 2'd2, 2'd0, 32'h0, 1'b0);          // R8 word split read
    access(1'b1, 2'd3, 2'd1, 32'h89ABCDEF, 1'b1);   // R8 word split write, R12 hold
    chk(narrow_o == 1'b1, "R1 strap change ignored", {31'b0, narrow_o}, 32'h1);
    for (int i = 0; i < 300; i++) begin
      width16_strap_i = ~width16_strap_i;
      access($urandom_range(0, 1), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
             $urandom, bit'($urandom_range(0, 1)));
    end
    chk(narrow_o == 1'b1, "R1 mode held after toggles", {31'b0, narrow_o}, 32'h1);

    // back to wide via reset
    do_reset(1'b0);
    width16_strap_i = 1'b1;
    access(1'b0, 2'd2, 2'd0, 32'h0, 1'b0);
    chk(narrow_o == 1'b0, "R1 wide held", {31'b0, narrow_o}, '0);

    summary();
    $finish;
  end
endmodule